// File: doc/BRIEF.md
# Supervisor Interrupt File Top-Claim Logic

This block keeps, for each external interrupt identity of a supervisor-level message-signalled interrupt file, one pending bit and one enable bit, together with a priority threshold. Every cycle it works out the most urgent interrupt that is pending, enabled and below the threshold. It presents that interrupt as a packed word, both on a continuous output and through a CSR access port at address 0x15C.

Incoming messages set pending bits through a set vector. The pending, enable and threshold state can also be loaded directly. A write to the CSR claims the interrupt the register shows at that moment and clears its pending bit; the written data is never used. A combined read-and-write returns the value from before the clear and clears that same identity in the same access. A later arrival of a more urgent interrupt therefore cannot be lost.

The CSR responder is a two-state machine. `ST_IDLE` waits for an access. `ST_RESP` drives the captured word for one cycle with `csr_rvalid` high. The transitions are:
- `IDLE->RESP`: an access hits 0x15C.
- `RESP->RESP`: an access hits 0x15C in the response cycle (back-to-back accesses).
- `RESP->IDLE`: no hit in the response cycle.
- `IDLE->IDLE`: no hit while idle.

Top module: `intr_file_claim`

## Requirements
- R1: After reset all pending bits, enable bits and the threshold are zero, `top_o` reads zero, and `csr_rvalid` is low with `csr_rdata` zero.
- R2: The top word carries the identity in bits 26:16 and the same number again in bits 10:0. Bits 15:11 and XLEN-1:27 are always zero, and the word is all zero when nothing qualifies.
- R3: Among identities that are both pending and enabled, the lowest number is chosen, and identity 0 is never chosen.
- R4: With a nonzero threshold T, only identities strictly below T qualify. A threshold of zero applies no filtering.
- R5: `csr_op` is encoded as 0 = none, 1 = read, 2 = write, 3 = read-and-write. Any nonzero op at address 0x15C gives `csr_rvalid`=1 in the next cycle, with `csr_rdata` equal to the top word of the access cycle. A plain read changes no state.
- R6: A write (op 2) ignores `csr_wdata` and clears only the pending bit of the identity the top word held in the access cycle.
- R7: A write or read-and-write while the top word is zero changes no pending bit, even when pending bits that do not qualify are set.
- R8: A read-and-write (op 3) returns the pre-clear top word and clears that identity. An interrupt that arrives in the same cycle is neither returned nor cleared.
- R9: When a `msg_set` bit and a claim name the same identity in the same cycle, the bit stays pending.
- R10: An access with any address other than 0x15C gives no `csr_rvalid` and claims nothing.
- R11: `pend_wr`, `en_wr` and `thr_wr` load their data on the next edge. Bit 0 of the pending and enable state stays zero whatever is loaded or set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_op | input | 2 | CSR access: 0 none, 1 read, 2 write, 3 read-and-write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data (ignored) |
| csr_rdata | output | XLEN | Captured top word in the response cycle, zero otherwise |
| csr_rvalid | output | 1 | Response cycle indicator |
| msg_set | input | NUM_IDS | Pending-set pulses from incoming messages |
| pend_wr | input | 1 | Load the pending vector |
| pend_wdata | input | NUM_IDS | Pending vector to load |
| en_wr | input | 1 | Load the enable vector |
| en_wdata | input | NUM_IDS | Enable vector to load |
| thr_wr | input | 1 | Load the threshold |
| thr_wdata | input | ID_W | Threshold value |
| top_o | output | XLEN | Continuous top word |
| pend_o | output | NUM_IDS | Current pending vector |

## Verification
The case that is hardest to reach from the ports is a read-and-write claim in the same cycle that a more urgent message arrives. The returned word and the cleared bit must both come from the old top, while the new arrival stays pending and becomes the next top. The bench lines up a `msg_set` pulse for a lower identity with the read-and-write strobe on the same edge. It then repeats the collision with the claimed identity itself, to reach the set-wins rule. A behavioural model checks every cycle, and directed checks cover threshold edges, an identity that is pending but disabled while a claim is made, and off-address accesses.

// File: rtl/intr_file_pkg.sv
package intr_file_pkg;

    localparam logic [11:0] CSR_TOP_ADDR = 12'h15C;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RMW   = 2'd3
    } csr_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

endpackage

// File: rtl/intr_pend_bank.sv
module intr_pend_bank #(
    parameter int NUM_IDS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] set_vec,
    input  logic [NUM_IDS-1:0] clr_vec,
    input  logic               load_en,
    input  logic [NUM_IDS-1:0] load_vec,
    output logic [NUM_IDS-1:0] bits_q
);

    logic unused_bit0;
    assign unused_bit0 = set_vec[0] ^ clr_vec[0] ^ load_vec[0];

    assign bits_q[0] = 1'b0;

    generate
        for (genvar i = 1; i < NUM_IDS; i++) begin : g_bit
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_vec[i]) begin
                    bit_q <= 1'b1;
                end else if (load_en) begin
                    bit_q <= load_vec[i];
                end else if (clr_vec[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign bits_q[i] = bit_q;
        end
    endgenerate

endmodule

// File: rtl/intr_top_sel.sv
module intr_top_sel #(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = 11
) (
    input  logic [NUM_IDS-1:0] pend,
    input  logic [NUM_IDS-1:0] en,
    input  logic [ID_W-1:0]    thr,
    output logic [ID_W-1:0]    top_id
);

    logic [NUM_IDS-1:0] qual;

    assign qual[0] = 1'b0;

    generate
        for (genvar i = 1; i < NUM_IDS; i++) begin : g_qual
            assign qual[i] = pend[i] & en[i] &
                             ((thr == '0) || (ID_W'(i) < thr));
        end
    endgenerate

    always_comb begin
        top_id = '0;
        for (int i = NUM_IDS - 1; i >= 1; i--) begin
            if (qual[i]) begin
                top_id = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/intr_csr_fsm.sv
module intr_csr_fsm
    import intr_file_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = 11,
    parameter int XLEN    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         csr_op,
    input  logic [11:0]        csr_addr,
    input  logic [ID_W-1:0]    top_id,
    input  logic [XLEN-1:0]    top_word,
    output logic [NUM_IDS-1:0] claim_vec,
    output logic [XLEN-1:0]    rdata,
    output logic               rvalid
);

    resp_state_e state_q, state_d;
    logic [XLEN-1:0] cap_q;
    logic hit, do_claim;

    assign hit      = (csr_addr == CSR_TOP_ADDR) && (csr_op != OP_NONE);
    assign do_claim = hit && ((csr_op == OP_WRITE) || (csr_op == OP_RMW))
                      && (top_id != '0);

    generate
        for (genvar i = 0; i < NUM_IDS; i++) begin : g_claim
            assign claim_vec[i] = do_claim && (top_id == ID_W'(i));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit) state_d = ST_RESP;
            ST_RESP: state_d = hit ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (hit) begin
            cap_q <= top_word;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            ST_IDLE: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
            ST_RESP: begin
                rvalid = 1'b1;
                rdata  = cap_q;
            end
        endcase
    end

endmodule

// File: rtl/intr_file_claim.sv
module intr_file_claim #(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = 11,
    parameter int XLEN    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         csr_op,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               csr_rvalid,
    input  logic [NUM_IDS-1:0] msg_set,
    input  logic               pend_wr,
    input  logic [NUM_IDS-1:0] pend_wdata,
    input  logic               en_wr,
    input  logic [NUM_IDS-1:0] en_wdata,
    input  logic               thr_wr,
    input  logic [ID_W-1:0]    thr_wdata,
    output logic [XLEN-1:0]    top_o,
    output logic [NUM_IDS-1:0] pend_o
);

    localparam int ID_LSB   = 16;
    localparam int HI_PAD_W = XLEN - ID_LSB - ID_W;
    localparam int MID_PAD_W = ID_LSB - ID_W;

    logic unused_wdata;
    assign unused_wdata = ^csr_wdata;

    logic [NUM_IDS-1:0] pend_q, en_q, claim_vec;
    logic [ID_W-1:0]    thr_q, top_id;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_wr) begin
            thr_q <= thr_wdata;
        end
    end

    intr_pend_bank #(.NUM_IDS(NUM_IDS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (msg_set),
        .clr_vec  (claim_vec),
        .load_en  (pend_wr),
        .load_vec (pend_wdata),
        .bits_q   (pend_q)
    );

    intr_pend_bank #(.NUM_IDS(NUM_IDS)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  ('0),
        .clr_vec  ('0),
        .load_en  (en_wr),
        .load_vec (en_wdata),
        .bits_q   (en_q)
    );

    intr_top_sel #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_sel (
        .pend   (pend_q),
        .en     (en_q),
        .thr    (thr_q),
        .top_id (top_id)
    );

    assign top_o = {{HI_PAD_W{1'b0}}, top_id, {MID_PAD_W{1'b0}}, top_id};

    intr_csr_fsm #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .XLEN(XLEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_op    (csr_op),
        .csr_addr  (csr_addr),
        .top_id    (top_id),
        .top_word  (top_o),
        .claim_vec (claim_vec),
        .rdata     (csr_rdata),
        .rvalid    (csr_rvalid)
    );

    assign pend_o = pend_q;

endmodule

// File: rtl/intr_file_claim_chk.sv
module intr_file_claim_chk #(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = 11,
    parameter int XLEN    = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         csr_op,
    input logic [11:0]        csr_addr,
    input logic [XLEN-1:0]    csr_rdata,
    input logic               csr_rvalid,
    input logic [NUM_IDS-1:0] msg_set,
    input logic               pend_wr,
    input logic [XLEN-1:0]    top_o,
    input logic [NUM_IDS-1:0] pend_o
);

    logic hit;
    logic [ID_W-1:0] tid;
    assign hit = (csr_addr == 12'h15C) && (csr_op != 2'd0);
    assign tid = top_o[16 +: ID_W];

    p_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (top_o[ID_W-1:0] == tid) && (top_o[15:ID_W] == '0) &&
        (top_o[XLEN-1:16+ID_W] == '0));

    p_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> csr_rvalid);

    p_pre_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (csr_rdata == $past(top_o)));

    p_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && csr_op[1] && (tid != '0) && !pend_wr && !msg_set[tid])
        |=> !pend_o[$past(tid)]);

    p_zero_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((tid == '0) && !pend_wr && (msg_set == '0)) |=> $stable(pend_o));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_set != '0) |=> ((pend_o & $past(msg_set)) == ($past(msg_set) & ~NUM_IDS'(1))));

    p_off_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !csr_rvalid);

    p_id0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_o[0]);

endmodule

bind intr_file_claim intr_file_claim_chk #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .XLEN(XLEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_op     (csr_op),
    .csr_addr   (csr_addr),
    .csr_rdata  (csr_rdata),
    .csr_rvalid (csr_rvalid),
    .msg_set    (msg_set),
    .pend_wr    (pend_wr),
    .top_o      (top_o),
    .pend_o     (pend_o)
);

// File: tb/intr_file_claim_test.sv
module intr_file_claim_test;

    localparam int N = 64;
    localparam int IW = 11;
    localparam int XL = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] csr_op = '0;
    logic [11:0] csr_addr = '0;
    logic [XL-1:0] csr_wdata = '0;
    logic [XL-1:0] csr_rdata;
    logic csr_rvalid;
    logic [N-1:0] msg_set = '0;
    logic pend_wr = 1'b0;
    logic [N-1:0] pend_wdata = '0;
    logic en_wr = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic thr_wr = 1'b0;
    logic [IW-1:0] thr_wdata = '0;
    logic [XL-1:0] top_o;
    logic [N-1:0] pend_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    intr_file_claim uut (
        .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid),
        .msg_set(msg_set), .pend_wr(pend_wr), .pend_wdata(pend_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .thr_wr(thr_wr),
        .thr_wdata(thr_wdata), .top_o(top_o), .pend_o(pend_o)
    );

    // behavioural reference model
    bit m_pend[N];
    bit m_en[N];
    int m_thr;
    bit m_rvalid;
    logic [XL-1:0] m_rdata;

    function automatic int model_top();
        for (int i = 1; i < N; i++) begin
            if (m_pend[i] && m_en[i] && (m_thr == 0 || i < m_thr)) return i;
        end
        return 0;
    endfunction

    function automatic logic [XL-1:0] word_of(int id);
        return (XL'(id) << 16) | XL'(id);
    endfunction

    function automatic logic [N-1:0] model_pend_vec();
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = m_pend[i];
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0;
                m_en[i] = 0;
            end
            m_thr = 0;
            m_rvalid = 0;
            m_rdata = '0;
        end else begin
            int t;
            bit h;
            t = model_top();
            h = (csr_addr == 12'h15C) && (csr_op != 0);
            m_rvalid = h;
            m_rdata = h ? word_of(t) : '0;
            for (int i = 1; i < N; i++) begin
                bit p;
                p = pend_wr ? pend_wdata[i] : m_pend[i];
                if (!pend_wr && h && csr_op[1] && t == i) p = 0;
                if (msg_set[i]) p = 1;
                m_pend[i] = p;
                if (en_wr) m_en[i] = en_wdata[i];
            end
            if (thr_wr) m_thr = int'(thr_wdata);
        end
    end

    task automatic chk(string req, logic [XL-1:0] act, logic [XL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 top", top_o, word_of(model_top()));
            chk("R6 pend", XL'(pend_o), XL'(model_pend_vec()));
            chk("R5 rvalid", XL'(csr_rvalid), XL'(m_rvalid));
            chk("R8 rdata", csr_rdata, m_rdata);
        end
    end

    task automatic tick();
        @(negedge clk);
        csr_op = 0; csr_addr = 0; csr_wdata = '0; msg_set = '0;
        pend_wr = 0; en_wr = 0; thr_wr = 0;
    endtask

    task automatic load_pend(logic [N-1:0] v);
        pend_wr = 1; pend_wdata = v; tick();
    endtask

    task automatic set_thr(int t);
        thr_wr = 1; thr_wdata = IW'(t); tick();
    endtask

    task automatic access(logic [1:0] op, logic [11:0] a);
        csr_op = op; csr_addr = a; csr_wdata = '1; tick();
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] p;
        repeat (2) @(negedge clk);
        chk("R1 top", top_o, '0);
        chk("R1 rvalid", XL'(csr_rvalid), '0);
        chk("R1 rdata", csr_rdata, '0);
        rst_n = 1;
        tick();
        chk("R1 pend", XL'(pend_o), '0);

        en_wr = 1; en_wdata = '1; tick();
        p = '0; p[5] = 1; p[9] = 1; p[40] = 1;
        load_pend(p);
        chk("R3 lowest", top_o, 64'h0005_0005);
        chk("R2 layout", top_o[XL-1:27] | XL'(top_o[15:11]), '0);

        set_thr(5);
        chk("R4 thr5", top_o, '0);
        set_thr(6);
        chk("R4 thr6", top_o, word_of(5));
        set_thr(0);
        chk("R4 thr0", top_o, word_of(5));

        access(2'd1, 12'h15C);
        chk("R5 rvalid", XL'(csr_rvalid), 1);
        chk("R5 rdata", csr_rdata, word_of(5));
        chk("R5 nochange", XL'(pend_o[5]), 1);

        access(2'd2, 12'h15C);
        chk("R6 cleared", XL'(pend_o[5]), 0);
        chk("R6 others", XL'(pend_o[9] & pend_o[40]), 1);
        chk("R6 next", top_o, word_of(9));

        // R8 race: arrival of id 2 together with read-and-write
        msg_set[2] = 1; access(2'd3, 12'h15C);
        chk("R8 rdata", csr_rdata, word_of(9));
        chk("R8 cleared", XL'(pend_o[9]), 0);
        chk("R8 arrival", top_o, word_of(2));

        // R9: set and claim on same id
        msg_set[2] = 1; access(2'd2, 12'h15C);
        chk("R9 stays", XL'(pend_o[2]), 1);

        // R10: off-address
        access(2'd3, 12'h15D);
        chk("R10 rvalid", XL'(csr_rvalid), 0);
        chk("R10 pend", XL'(pend_o[2]), 1);

        // R7: pending but disabled, then blocked by threshold
        en_wr = 1; en_wdata = '1; en_wdata[3] = 0; tick();
        p = '0; p[3] = 1; load_pend(p);
        access(2'd2, 12'h15C);
        chk("R7 disabled", XL'(pend_o[3]), 1);
        p = '0; p[20] = 1; load_pend(p);
        set_thr(20);
        access(2'd3, 12'h15C);
        chk("R7 thr", XL'(pend_o[20]), 1);
        chk("R7 rdata", csr_rdata, '0);
        set_thr(0);

        // R11: id 0 tied off, max id
        p = '0; p[0] = 1; p[63] = 1; load_pend(p);
        chk("R11 id0", XL'(pend_o[0]), 0);
        chk("R11 max", top_o, word_of(63));
        msg_set[0] = 1; tick();
        chk("R11 set0", XL'(pend_o[0]), 0);

        // back-to-back claims
        p = '0; p[7] = 1; p[8] = 1; load_pend(p);
        csr_op = 2'd3; csr_addr = 12'h15C; @(negedge clk);
        chk("R5 b2b1", csr_rdata, word_of(7));
        csr_op = 2'd3; csr_addr = 12'h15C; tick();
        chk("R8 b2b2", csr_rdata, word_of(8));
        tick();
        chk("R5 idle", XL'(csr_rvalid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule